// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides, for both ALU operands of the instruction now in the execute stage, where each operand value should come from. There are three possible sources: the value the register file produced in decode, the ALU result held in the register after execute, or the final value about to be written back. It compares the two source register indices of the executing instruction with the destination indices of the two older instructions still in flight. It returns a 2-bit select and the chosen 32-bit value for each operand.

The block also detects the one dependency that forwarding cannot resolve: a load in the stage after execute whose destination a source of the executing instruction needs. In that case it raises a stall request. The surrounding pipeline holds the PC and the fetch/decode register for one cycle and injects a bubble into the decode/execute register. After that one cycle the loaded data has reached the writeback stage, and the normal writeback path supplies it. The block has no storage: every output follows its inputs within the same cycle.

Top module: `exfwd_unit`

## Requirements
- R1: Operand A takes select code 2'b10 and the value on `mem_alu_i` when `mem_wen_i` is 1, `mem_dst_i` is nonzero, `mem_is_load_i` is 0 and `src_a_i` equals `mem_dst_i`.
- R2: Operand B follows the R1 rule with `src_b_i`, independently of operand A.
- R3: An operand takes select code 2'b01 and the value on `wb_data_i` when `wb_wen_i` is 1, `wb_dst_i` is nonzero, its source equals `wb_dst_i`, and the R1 condition (without the load term) does not hold for that operand.
- R4: When the memory-stage and writeback-stage destinations both match an operand, the memory stage wins and code 2'b01 is never chosen.
- R5: A source index of 0 never selects a forwarded value, even when a writing stage has destination 0.
- R6: A stage whose write enable is 0, such as a store, is never a forwarding source, whatever its destination field holds.
- R7: With no forwarding condition, an operand uses select code 2'b00 and passes its register-file value through. Code 2'b11 never appears.
- R8: When `mem_is_load_i` is 1 and the memory-stage match of R1 holds for an operand, `stall_o` is 1 and that operand uses code 2'b00.
- R9: `stall_o` is 0 whenever no operand meets the R8 condition. This includes loads to register 0, loads with write enable 0, and non-load matches.
- R10: All outputs are combinational: a change on any input shows on the outputs within the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_i | input | 3 | Source index of operand A in execute |
| src_b_i | input | 3 | Source index of operand B in execute |
| rf_a_i | input | 32 | Register-file value of operand A |
| rf_b_i | input | 32 | Register-file value of operand B |
| mem_dst_i | input | 3 | Destination index of the memory-stage instruction |
| mem_wen_i | input | 1 | Memory-stage instruction writes a register |
| mem_is_load_i | input | 1 | Memory-stage instruction is a load |
| mem_alu_i | input | 32 | ALU result held after execute |
| wb_dst_i | input | 3 | Destination index of the writeback-stage instruction |
| wb_wen_i | input | 1 | Writeback-stage instruction writes a register |
| wb_data_i | input | 32 | Final writeback value (load data or ALU result) |
| sel_a_o | output | 2 | Operand A source: 00 regfile, 10 memory stage, 01 writeback |
| sel_b_o | output | 2 | Operand B source, same encoding |
| opnd_a_o | output | 32 | Chosen operand A value |
| opnd_b_o | output | 32 | Chosen operand B value |
| stall_o | output | 1 | Load-use stall request |

## Verification
The block holds no state, so a faulty compare or priority shows at the select and operand ports in the same cycle as the input pattern that triggers it. A wrong priority would show as code 01 where 10 belongs. A missing zero-index guard would show as a forwarded value where the register-file value belongs. A wrong load term would show as a stall without a load, or as a stale ALU value selected during a load-use case. Random patterns use only eight register indices, so matches, double matches and index-0 cases occur often. Directed patterns pin down each of these cases.

// File: rtl/exfwd_pkg.sv
package exfwd_pkg;

    parameter int unsigned XLEN      = 32;
    parameter int unsigned REG_IDX_W = 3;
    parameter int unsigned N_OPND    = 2;

    typedef enum logic [1:0] {
        OPSRC_REGFILE  = 2'b00,
        OPSRC_WB       = 2'b01,
        OPSRC_MEMSTAGE = 2'b10
    } opsrc_e;

    typedef struct packed {
        logic mem_hit;
        logic wb_hit;
    } hit_t;

    function automatic logic idx_hit(input logic wen,
                                     input logic [REG_IDX_W-1:0] dst,
                                     input logic [REG_IDX_W-1:0] src);
        return wen && (dst != '0) && (dst == src);
    endfunction

endpackage

// File: rtl/exfwd_hit_cmp.sv
module exfwd_hit_cmp
    import exfwd_pkg::*;
(
    input  logic [REG_IDX_W-1:0] src_i,
    input  logic                 mem_wen_i,
    input  logic [REG_IDX_W-1:0] mem_dst_i,
    input  logic                 wb_wen_i,
    input  logic [REG_IDX_W-1:0] wb_dst_i,
    output hit_t                 hit_o
);

    always_comb begin
        hit_o.mem_hit = idx_hit(mem_wen_i, mem_dst_i, src_i);
        hit_o.wb_hit  = idx_hit(wb_wen_i, wb_dst_i, src_i);
    end

    // R5: index 0 never matches any stage
    always_comb begin
        if (src_i == '0) begin
            a_r5_zero_no_hit: assert (hit_o == '0)
                else $error("R5: hit on source index 0");
        end
    end

endmodule

// File: rtl/exfwd_opnd_sel.sv
module exfwd_opnd_sel
    import exfwd_pkg::*;
#(
    parameter int unsigned DATA_W = XLEN
)(
    input  hit_t              hit_i,
    input  logic              mem_is_load_i,
    input  logic [DATA_W-1:0] rf_val_i,
    input  logic [DATA_W-1:0] mem_val_i,
    input  logic [DATA_W-1:0] wb_val_i,
    output opsrc_e            sel_o,
    output logic [DATA_W-1:0] val_o
);

    always_comb begin
        if (hit_i.mem_hit) begin
            sel_o = mem_is_load_i ? OPSRC_REGFILE : OPSRC_MEMSTAGE;
        end else if (hit_i.wb_hit) begin
            sel_o = OPSRC_WB;
        end else begin
            sel_o = OPSRC_REGFILE;
        end
    end

    always_comb begin
        unique case (sel_o)
            OPSRC_MEMSTAGE: val_o = mem_val_i;
            OPSRC_WB:       val_o = wb_val_i;
            default:        val_o = rf_val_i;
        endcase
    end

    always_comb begin
        a_r7_sel_legal: assert (sel_o != opsrc_e'(2'b11))
            else $error("R7: illegal select code");
        if (hit_i.mem_hit) begin
            a_r4_mem_over_wb: assert (sel_o != OPSRC_WB)
                else $error("R4: writeback chosen over memory stage");
        end
    end

endmodule

// File: rtl/exfwd_load_hazard.sv
module exfwd_load_hazard
    import exfwd_pkg::*;
#(
    parameter int unsigned N = N_OPND
)(
    input  hit_t hit_i [N],
    input  logic mem_is_load_i,
    output logic stall_o
);

    logic any_mem_hit;

    always_comb begin
        any_mem_hit = 1'b0;
        for (int k = 0; k < N; k++) begin
            any_mem_hit = any_mem_hit | hit_i[k].mem_hit;
        end
        stall_o = mem_is_load_i & any_mem_hit;
    end

    always_comb begin
        if (stall_o) begin
            a_r9_stall_needs_load: assert (mem_is_load_i)
                else $error("R9: stall without a load");
        end
    end

endmodule

// File: rtl/exfwd_unit.sv
module exfwd_unit
    import exfwd_pkg::*;
#(
    parameter int unsigned IDX_W  = REG_IDX_W,
    parameter int unsigned DATA_W = XLEN
)(
    input  logic [IDX_W-1:0]  src_a_i,
    input  logic [IDX_W-1:0]  src_b_i,
    input  logic [DATA_W-1:0] rf_a_i,
    input  logic [DATA_W-1:0] rf_b_i,
    input  logic [IDX_W-1:0]  mem_dst_i,
    input  logic              mem_wen_i,
    input  logic              mem_is_load_i,
    input  logic [DATA_W-1:0] mem_alu_i,
    input  logic [IDX_W-1:0]  wb_dst_i,
    input  logic              wb_wen_i,
    input  logic [DATA_W-1:0] wb_data_i,
    output logic [1:0]        sel_a_o,
    output logic [1:0]        sel_b_o,
    output logic [DATA_W-1:0] opnd_a_o,
    output logic [DATA_W-1:0] opnd_b_o,
    output logic              stall_o
);

    localparam int unsigned NOP = N_OPND;

    logic [IDX_W-1:0]  src  [NOP];
    logic [DATA_W-1:0] rfv  [NOP];
    hit_t              hit  [NOP];
    opsrc_e            sel  [NOP];
    logic [DATA_W-1:0] val  [NOP];

    assign src[0] = src_a_i;
    assign src[1] = src_b_i;
    assign rfv[0] = rf_a_i;
    assign rfv[1] = rf_b_i;

    for (genvar k = 0; k < NOP; k++) begin : g_opnd
        exfwd_hit_cmp u_cmp (
            .src_i     (src[k]),
            .mem_wen_i (mem_wen_i),
            .mem_dst_i (mem_dst_i),
            .wb_wen_i  (wb_wen_i),
            .wb_dst_i  (wb_dst_i),
            .hit_o     (hit[k])
        );

        exfwd_opnd_sel #(.DATA_W(DATA_W)) u_sel (
            .hit_i         (hit[k]),
            .mem_is_load_i (mem_is_load_i),
            .rf_val_i      (rfv[k]),
            .mem_val_i     (mem_alu_i),
            .wb_val_i      (wb_data_i),
            .sel_o         (sel[k]),
            .val_o         (val[k])
        );
    end

    exfwd_load_hazard #(.N(NOP)) u_lhz (
        .hit_i         (hit),
        .mem_is_load_i (mem_is_load_i),
        .stall_o       (stall_o)
    );

    assign sel_a_o  = sel[0];
    assign sel_b_o  = sel[1];
    assign opnd_a_o = val[0];
    assign opnd_b_o = val[1];

    always_comb begin
        // R6: a non-writing memory stage is never a source
        if (!mem_wen_i) begin
            a_r6_no_wen_mem: assert (sel_a_o != 2'b10 && sel_b_o != 2'b10 && !stall_o)
                else $error("R6: forwarded from non-writing stage");
        end
        // R8: a stalled load never hands its stale ALU value forward
        if (stall_o) begin
            a_r8_load_no_fwd: assert (sel_a_o != 2'b10 && sel_b_o != 2'b10)
                else $error("R8: load result forwarded from memory stage");
        end
        // R1: memory-stage select delivers the ALU result
        if (sel_a_o == 2'b10) begin
            a_r1_mem_value_a: assert (opnd_a_o == mem_alu_i)
                else $error("R1: wrong operand A value");
        end
    end

endmodule

// File: tb/exfwd_unit_tb.sv
module exfwd_unit_tb_top;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [2:0]  src_a, src_b, mem_dst, wb_dst;
    logic [31:0] rf_a, rf_b, mem_alu, wb_data;
    logic        mem_wen, mem_ld, wb_wen;
    logic [1:0]  sel_a, sel_b;
    logic [31:0] opnd_a, opnd_b;
    logic        stall;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    exfwd_unit dut_i (
        .src_a_i(src_a), .src_b_i(src_b), .rf_a_i(rf_a), .rf_b_i(rf_b),
        .mem_dst_i(mem_dst), .mem_wen_i(mem_wen), .mem_is_load_i(mem_ld),
        .mem_alu_i(mem_alu), .wb_dst_i(wb_dst), .wb_wen_i(wb_wen),
        .wb_data_i(wb_data), .sel_a_o(sel_a), .sel_b_o(sel_b),
        .opnd_a_o(opnd_a), .opnd_b_o(opnd_b), .stall_o(stall)
    );

    function automatic logic mem_match(input logic [2:0] s);
        return mem_wen && mem_dst != 3'd0 && mem_dst == s;
    endfunction

    function automatic logic [1:0] exp_sel(input logic [2:0] s);
        if (mem_match(s)) return mem_ld ? 2'b00 : 2'b10;
        if (wb_wen && wb_dst != 3'd0 && wb_dst == s) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [31:0] exp_val(input logic [1:0] sl, input logic [31:0] rf);
        case (sl)
            2'b10:   return mem_alu;
            2'b01:   return wb_data;
            default: return rf;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Sample half a cycle after drive: same cycle as the input change (R10)
    task automatic check_all(input string tag);
        logic [1:0] ea, eb;
        logic       es;
        @(negedge clk);
        ea = exp_sel(src_a);
        eb = exp_sel(src_b);
        es = mem_ld && (mem_match(src_a) || mem_match(src_b));
        chk({tag, " sel_a"}, 32'(sel_a), 32'(ea));
        chk({tag, " sel_b"}, 32'(sel_b), 32'(eb));
        chk({tag, " opnd_a"}, opnd_a, exp_val(ea, rf_a));
        chk({tag, " opnd_b"}, opnd_b, exp_val(eb, rf_b));
        chk({tag, " stall"}, 32'(stall), 32'(es));
    endtask

    task automatic drive(input logic [2:0] sa, input logic [2:0] sb,
                         input logic [2:0] md, input logic mw, input logic ml,
                         input logic [2:0] wd, input logic ww);
        @(posedge clk);
        src_a = sa; src_b = sb; mem_dst = md; mem_wen = mw; mem_ld = ml;
        wb_dst = wd; wb_wen = ww;
        rf_a = 32'hA000_0000 | 32'(sa); rf_b = 32'hB000_0000 | 32'(sb);
        mem_alu = 32'hC0DE_0001; wb_data = 32'h5EED_0002;
    endtask

    initial begin
        src_a = '0; src_b = '0; mem_dst = '0; wb_dst = '0;
        rf_a = '0; rf_b = '0; mem_alu = '0; wb_data = '0;
        mem_wen = 0; mem_ld = 0; wb_wen = 0;
        void'($urandom(32'd2024));

        // idle state: nothing in flight
        check_all("R7 idle");
        drive(3'd1, 3'd2, 3'd0, 0, 0, 3'd0, 0); check_all("R7 no hazard");
        drive(3'd3, 3'd4, 3'd3, 1, 0, 3'd5, 1); check_all("R1 mem to A");
        drive(3'd6, 3'd5, 3'd5, 1, 0, 3'd1, 1); check_all("R2 mem to B");
        drive(3'd2, 3'd7, 3'd4, 1, 0, 3'd2, 1); check_all("R3 wb to A");
        drive(3'd3, 3'd3, 3'd3, 1, 0, 3'd3, 1); check_all("R4 both match");
        drive(3'd0, 3'd0, 3'd0, 1, 0, 3'd0, 1); check_all("R5 index zero");
        drive(3'd4, 3'd4, 3'd4, 0, 0, 3'd4, 0); check_all("R6 no write enable");
        drive(3'd4, 3'd1, 3'd4, 0, 1, 3'd4, 1); check_all("R6 store then wb");
        drive(3'd5, 3'd2, 3'd5, 1, 1, 3'd5, 1); check_all("R8 load use A");
        drive(3'd1, 3'd6, 3'd6, 1, 1, 3'd0, 0); check_all("R8 load use B");
        drive(3'd0, 3'd1, 3'd0, 1, 1, 3'd0, 0); check_all("R9 load to r0");
        drive(3'd2, 3'd3, 3'd4, 1, 1, 3'd2, 1); check_all("R9 load no match");
        drive(3'd2, 3'd3, 3'd2, 1, 0, 3'd3, 1); check_all("R10 back to back");

        for (int i = 0; i < 3000; i++) begin
            @(posedge clk);
            src_a = 3'($urandom); src_b = 3'($urandom);
            mem_dst = 3'($urandom); wb_dst = 3'($urandom);
            mem_wen = 1'($urandom); mem_ld = 1'($urandom); wb_wen = 1'($urandom);
            rf_a = $urandom; rf_b = $urandom; mem_alu = $urandom; wb_data = $urandom;
            check_all("R1 R2 R3 R4 R8 R9 random");
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule